// File: doc/BRIEF.md
# Four-Phase Control-Register Bus Master

This block turns single register commands from a host into the strobe sequence that a PHY-side control-register bus expects. The host presents a 16-bit address, 16-bit write data and a read/write flag with a valid/ready handshake. The block then runs the access as a chain of phases on the bus. Each phase is a full four-phase handshake on one acknowledge line: raise one strobe, wait for the acknowledge to rise, drop the strobe, and wait for the acknowledge to fall.

Address and write data share a single 16-bit `bus_din` field. Read data comes back on a separate `bus_dout` field and is sampled while the acknowledge is high. Each wait for the acknowledge is bounded by a cycle counter. If a wait runs out, the command is abandoned, every strobe drops, and the response reports an error. Only one command is in flight at a time.

Top module: `rcb_master`

## Requirements
- R1: After reset and whenever idle, all four strobes are low, `cmd_ready` is high and `rsp_valid` is low.
- R2: At most one of `bus_cap_addr`, `bus_cap_data`, `bus_wr`, `bus_rd` is high in any cycle.
- R3: Every access starts with an address phase. `bus_din` carries `cmd_addr` for at least `SETUP_CYC` cycles with no strobe high, and only then does `bus_cap_addr` rise.
- R4: In every phase the strobe stays high until `bus_ack` is seen high, then drops. The next phase, or the response, starts only after `bus_ack` is seen low.
- R5: A write (`cmd_read`=0) runs three phases in order: capture-address, then capture-data, then write. `bus_din` holds `cmd_wdata` for at least `SETUP_CYC` cycles before capture-data rises, and it does not change while the data or write strobes are high.
- R6: A read (`cmd_read`=1) runs capture-address, then one cycle with all strobes low and `bus_din`=0, then the read strobe. The value on `bus_dout` while `bus_ack` is high is returned on `rsp_rdata`.
- R7: If `bus_ack` fails to rise or to fall within `TIMEOUT_CYC` cycles of a wait starting, the command is abandoned. All strobes drop, and the response carries `rsp_err`=1 and `rsp_rdata`=0. With no acknowledge at all, the response appears `SETUP_CYC`+`TIMEOUT_CYC`+1 cycles after acceptance. The next command then runs normally.
- R8: `rsp_valid` is a one-cycle pulse per accepted command. `cmd_ready` is low from acceptance until after that pulse, and a successful write returns `rsp_err`=0.
- R9: The timeout budget restarts at every wait. An access whose individual waits are each within `TIMEOUT_CYC` completes without error, even when its total length exceeds `TIMEOUT_CYC` many times over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Block is idle and takes the command |
| cmd_addr | input | 16 | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_read | input | 1 | 1 = read, 0 = write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Command abandoned on timeout |
| bus_din | output | 16 | Shared address/data field to the PHY |
| bus_cap_addr | output | 1 | Capture-address strobe |
| bus_cap_data | output | 1 | Capture-data strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_ack | input | 1 | Acknowledge from the PHY |
| bus_dout | input | 16 | Read data from the PHY |

## Verification
The hardest case to reach from the ports is a timeout on the falling edge of the acknowledge, where the PHY accepted a strobe but never released. The bench's PHY model has a mode that leaves the acknowledge latched high. A reset afterwards clears the model before the next test. A second hard case is a long access that stays inside the budget only because the timer restarts at every wait. To exercise it, the model delays each acknowledge edge to just under the limit, so the whole access lasts several budgets.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    localparam int CRB_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_RESP
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_WRITE,
        PH_READ
    } phase_e;

    typedef struct packed {
        logic [CRB_W-1:0] addr;
        logic [CRB_W-1:0] wdata;
        logic             is_read;
    } cmd_t;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic wr;
        logic rd;
    } strobe_t;

    function automatic phase_e phase_after(phase_e p, logic is_read);
        case (p)
            PH_ADDR: phase_after = is_read ? PH_READ : PH_DATA;
            PH_DATA: phase_after = PH_WRITE;
            default: phase_after = PH_ADDR;
        endcase
    endfunction

    function automatic logic phase_is_last(phase_e p);
        phase_is_last = (p == PH_WRITE) || (p == PH_READ);
    endfunction

    function automatic strobe_t strobe_of(phase_e p);
        strobe_t s;
        s = '0;
        case (p)
            PH_ADDR:  s.cap_addr = 1'b1;
            PH_DATA:  s.cap_data = 1'b1;
            PH_WRITE: s.wr       = 1'b1;
            default:  s.rd       = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rcb_wait_timer.sv
module rcb_wait_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rcb_seq.sv
module rcb_seq
    import rcb_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 1000,
    parameter int CNT_W       = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  cmd_t             cmd_in,
    output logic             cmd_ready,
    input  logic             ack,
    input  logic [CRB_W-1:0] dout,
    input  logic [CNT_W-1:0] cnt,
    output logic             clr,
    output seq_state_e       state,
    output phase_e           phase,
    output cmd_t             cmd_q,
    output logic             rsp_valid,
    output logic [CRB_W-1:0] rsp_rdata,
    output logic             rsp_err
);

    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_e       state_n;
    phase_e           phase_n;
    logic             setup_done;
    logic             wait_over;
    logic             abort;
    logic             accept;
    logic [CRB_W-1:0] rdata_q;
    logic             err_q;

    // The gap before the read strobe is a single cycle; other phases use the full setup.
    assign setup_done = (phase == PH_READ) ? 1'b1 : (cnt >= SETUP_LAST);
    assign wait_over  = (cnt >= WAIT_LAST);
    assign accept     = (state == ST_IDLE) && cmd_valid;

    always_comb begin
        state_n = state;
        phase_n = phase;
        abort   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_n = ST_SETUP;
                    phase_n = PH_ADDR;
                end
            end
            ST_SETUP: begin
                if (setup_done) state_n = ST_STROBE;
            end
            ST_STROBE: begin
                if (ack) begin
                    state_n = ST_RELEASE;
                end else if (wait_over) begin
                    state_n = ST_RESP;
                    abort   = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!ack) begin
                    if (phase_is_last(phase)) begin
                        state_n = ST_RESP;
                    end else begin
                        state_n = ST_SETUP;
                        phase_n = phase_after(phase, cmd_q.is_read);
                    end
                end else if (wait_over) begin
                    state_n = ST_RESP;
                    abort   = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Restart the shared counter on every state or phase change.
    assign clr = (state_n != state) || (phase_n != phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            cmd_q   <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            if (accept) begin
                cmd_q   <= cmd_in;
                rdata_q <= '0;
                err_q   <= 1'b0;
            end
            if (state == ST_STROBE && ack && phase == PH_READ) begin
                rdata_q <= dout;
            end
            if (abort) begin
                rdata_q <= '0;
                err_q   <= 1'b1;
            end
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;

endmodule

// File: rtl/rcb_bus_drive.sv
module rcb_bus_drive
    import rcb_pkg::*;
(
    input  seq_state_e       state,
    input  phase_e           phase,
    input  cmd_t             cmd_q,
    output logic [CRB_W-1:0] din,
    output strobe_t          stb
);

    logic active;

    assign active = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_RELEASE);

    always_comb begin
        din = '0;
        if (active) begin
            case (phase)
                PH_ADDR:  din = cmd_q.addr;
                PH_DATA:  din = cmd_q.wdata;
                PH_WRITE: din = cmd_q.wdata;
                default:  din = '0;
            endcase
        end
    end

    assign stb = (state == ST_STROBE) ? strobe_of(phase) : '0;

endmodule

// File: rtl/rcb_master.sv
module rcb_master
    import rcb_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CRB_W-1:0] cmd_addr,
    input  logic [CRB_W-1:0] cmd_wdata,
    input  logic             cmd_read,
    output logic             rsp_valid,
    output logic [CRB_W-1:0] rsp_rdata,
    output logic             rsp_err,
    output logic [CRB_W-1:0] bus_din,
    output logic             bus_cap_addr,
    output logic             bus_cap_data,
    output logic             bus_wr,
    output logic             bus_rd,
    input  logic             bus_ack,
    input  logic [CRB_W-1:0] bus_dout
);

    localparam int CNT_MAX = (TIMEOUT_CYC > SETUP_CYC) ? TIMEOUT_CYC : SETUP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    cmd_t             cmd_in;
    cmd_t             cmd_q;
    seq_state_e       state;
    phase_e           phase;
    logic             clr;
    logic [CNT_W-1:0] cnt;
    strobe_t          stb;

    assign cmd_in = '{addr: cmd_addr, wdata: cmd_wdata, is_read: cmd_read};

    rcb_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .cnt (cnt)
    );

    rcb_seq #(
        .SETUP_CYC   (SETUP_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_in),
        .cmd_ready (cmd_ready),
        .ack       (bus_ack),
        .dout      (bus_dout),
        .cnt       (cnt),
        .clr       (clr),
        .state     (state),
        .phase     (phase),
        .cmd_q     (cmd_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    rcb_bus_drive u_drive (
        .state (state),
        .phase (phase),
        .cmd_q (cmd_q),
        .din   (bus_din),
        .stb   (stb)
    );

    assign bus_cap_addr = stb.cap_addr;
    assign bus_cap_data = stb.cap_data;
    assign bus_wr       = stb.wr;
    assign bus_rd       = stb.rd;

endmodule

// File: rtl/rcb_master_chk.sv
module rcb_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [15:0] rsp_rdata,
    input logic [15:0] bus_din,
    input logic        bus_cap_addr,
    input logic        bus_cap_data,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_ack
);

    logic stb_any;
    assign stb_any = bus_cap_addr | bus_cap_data | bus_wr | bus_rd;

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_cap_addr, bus_cap_data, bus_wr, bus_rd}));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !stb_any && !rsp_valid);

    p_strobe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (stb_any && !bus_ack) |=> (stb_any || rsp_valid));

    p_done_after_release_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> !bus_ack && !stb_any);

    p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_cap_data || bus_wr) |-> $stable(bus_din));

    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 16'h0) && !stb_any);

    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && cmd_ready);

endmodule

bind rcb_master rcb_master_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_ready    (cmd_ready),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .bus_din      (bus_din),
    .bus_cap_addr (bus_cap_addr),
    .bus_cap_data (bus_cap_data),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_ack      (bus_ack)
);

// File: tb/sim_rcb_master.sv
module sim_rcb_master;

    localparam int SETUP = 2;
    localparam int TOUT  = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [15:0] cmd_addr;
    logic [15:0] cmd_wdata;
    logic        cmd_read;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic [15:0] bus_din;
    logic        bus_cap_addr;
    logic        bus_cap_data;
    logic        bus_wr;
    logic        bus_rd;
    logic        bus_ack;
    logic [15:0] bus_dout;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rcb_master #(.SETUP_CYC(SETUP), .TIMEOUT_CYC(TOUT)) u0 (.*);

    // PHY model settings (written by the test tasks only)
    int   ack_dly  = 1;
    logic no_ack   = 1'b0;
    logic stuck    = 1'b0;

    // PHY model state (written by the model only)
    logic [15:0] mem [16];
    logic [15:0] cap_a, cap_d, prev_din;
    logic        prev_stb;
    int          dcnt, hold;
    int          ev_cnt, multi_err, setup_err;
    logic [15:0] ev_log;

    always @(posedge clk) begin
        logic [3:0] s;
        s = {bus_cap_addr, bus_cap_data, bus_wr, bus_rd};
        if (rst) begin
            bus_ack <= 1'b0;
            bus_dout <= 16'hDEAD;
            for (int i = 0; i < 16; i++) mem[i] = 16'h0;
            cap_a = '0; cap_d = '0; prev_din = '0; prev_stb = 1'b0;
            dcnt = 0; hold = 0; ev_cnt = 0; multi_err = 0; setup_err = 0; ev_log = '0;
        end else begin
            if ($countones(s) > 1) multi_err++;
            if (bus_din == prev_din) hold++; else hold = 1;
            prev_din = bus_din;
            if ((|s) && !prev_stb && !bus_rd && hold < SETUP + 1) setup_err++;
            prev_stb = |s;
            if ((|s) && !bus_ack && !no_ack) begin
                if (dcnt >= ack_dly) begin
                    dcnt = 0;
                    bus_ack <= 1'b1;
                    ev_cnt++;
                    if (bus_cap_addr) begin cap_a = bus_din; ev_log = {ev_log[11:0], 4'h1}; end
                    if (bus_cap_data) begin cap_d = bus_din; ev_log = {ev_log[11:0], 4'h2}; end
                    if (bus_wr) begin mem[cap_a[3:0]] = bus_din; ev_log = {ev_log[11:0], 4'h3}; end
                    if (bus_rd) begin bus_dout <= mem[cap_a[3:0]]; ev_log = {ev_log[11:0], 4'h4}; end
                end else dcnt++;
            end else if (!(|s) && bus_ack && !stuck) begin
                if (dcnt >= ack_dly) begin
                    dcnt = 0;
                    bus_ack <= 1'b0;
                    bus_dout <= 16'hDEAD;
                end else dcnt++;
            end else dcnt = 0;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic rd, input logic [15:0] a, input logic [15:0] wd,
                           output logic [15:0] rdata, output logic err, output int lat,
                           output int busy_ready, output logic pulse_ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_addr = 16'hFFFF; cmd_wdata = 16'hFFFF;
        lat = 1; busy_ready = 0;
        while (!rsp_valid && lat < 2000) begin
            if (cmd_ready) busy_ready++;
            @(negedge clk);
            lat++;
        end
        rdata = rsp_rdata; err = rsp_err;
        @(negedge clk);
        pulse_ok = !rsp_valid && cmd_ready;
    endtask

    task automatic do_reset;
        no_ack = 1'b0; stuck = 1'b0; ack_dly = 1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ready after reset", cmd_ready, 1);
        check("R1 strobes low", {bus_cap_addr, bus_cap_data, bus_wr, bus_rd}, 0);
        check("R1 no response", rsp_valid, 0);
    endtask

    task automatic t_write_read(input logic [15:0] a, input logic [15:0] d, input int dly);
        logic [15:0] rdv; logic e, p; int lat, br, ev0;
        ack_dly = dly;
        ev0 = ev_cnt;
        run_cmd(1'b0, a, d, rdv, e, lat, br, p);
        check("R5 write events", ev_cnt - ev0, 3);
        check("R5 write order", ev_log[11:0], 12'h123);
        check("R8 write no error", e, 0);
        check("R8 ready low while busy", br, 0);
        check("R8 single pulse", p, 1);
        ev0 = ev_cnt;
        run_cmd(1'b1, a, 16'h0, rdv, e, lat, br, p);
        check("R6 read events", ev_cnt - ev0, 2);
        check("R6 read order", ev_log[7:0], 8'h14);
        check("R6 read data", rdv, d);
        check("R6 read no error", e, 0);
        check("R3 setup respected", setup_err, 0);
        check("R2 one strobe", multi_err, 0);
    endtask

    task automatic t_no_ack;
        logic [15:0] rdv; logic e, p; int lat, br;
        no_ack = 1'b1;
        run_cmd(1'b1, 16'h0003, 16'h0, rdv, e, lat, br, p);
        check("R7 timeout error", e, 1);
        check("R7 timeout data zero", rdv, 0);
        check("R7 timeout latency", lat, SETUP + TOUT + 1);
        check("R7 strobes low after abort", {bus_cap_addr, bus_cap_data, bus_wr, bus_rd}, 0);
        check("R8 ready after abort", p, 1);
        no_ack = 1'b0;
        run_cmd(1'b1, 16'h0005, 16'h0, rdv, e, lat, br, p);
        check("R7 recovery no error", e, 0);
        check("R7 recovery data", rdv, 16'h5A5A);
    endtask

    task automatic t_stuck_ack;
        logic [15:0] rdv; logic e, p; int lat, br;
        stuck = 1'b1;
        run_cmd(1'b0, 16'h0007, 16'h1234, rdv, e, lat, br, p);
        check("R4 release timeout error", e, 1);
        check("R4 no write after stuck ack", ev_log[3:0], 4'h1);
        check("R4 stuck ack seen high", bus_ack, 1);
    endtask

    task automatic t_long_waits;
        logic [15:0] rdv; logic e, p; int lat, br;
        ack_dly = TOUT - 4;
        run_cmd(1'b1, 16'h0005, 16'h0, rdv, e, lat, br, p);
        check("R9 long access no error", e, 0);
        check("R9 long access data", rdv, 16'h5A5A);
        check("R9 longer than one budget", lat > 3 * TOUT, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cmd_valid = 1'b0; cmd_read = 1'b0; cmd_addr = '0; cmd_wdata = '0;
        do_reset();
        t_reset();
        t_write_read(16'h0005, 16'h5A5A, 1);
        t_write_read(16'h000A, 16'hC3E1, 0);
        t_write_read(16'h0000, 16'hFFFF, 3);
        t_no_ack();
        t_long_waits();
        t_stuck_ack();
        do_reset();
        t_reset();
        t_write_read(16'h0002, 16'h0F0F, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule